// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor that completes one instruction in every clock cycle. Each cycle it fetches a word from a private instruction memory at the program counter and splits it into fields by one of three fixed 32-bit layouts. It then reads two registers, computes a result or an address, and optionally touches a private data memory. Before the next edge it commits either one register write or one memory write, together with the next program counter.

The instruction memory is filled through a simple write port, normally while reset holds the core. The commit of every instruction is visible at the ports as a register writeback bus and a data memory write bus, next to the current program counter. A program can therefore be followed instruction by instruction from outside.

Top module: `sc_core`

## Requirements
- R1: While rst_n is low the PC is 32'h0040_0000 from the next edge on, and wb_en and mem_we are low. After release, the first instruction fetched is the one at instruction word 0.
- R2: With opcode 6'b000000, funct selects the operation. 100000 is add and 100010 is sub (rs minus rt). 100100 is and, 100101 is or, 100110 is xor and 100111 is nor. 101010 is signed set-less-than. 000000, 000010 and 000011 shift rt by shamt: left, logical right and arithmetic right. The result goes to rd.
- R3: ADDI (001000) writes rs plus the sign-extended imm[15:0] to rt. ORI (001101) ORs in the zero-extended immediate. LUI (001111) writes {imm, 16'h0}.
- R4: Register 0 reads as zero. An instruction aimed at register 0 raises no writeback.
- R5: SW (101011) writes rt to the data word at rs plus the sign-extended offset, and mem_addr shows that byte address. LW (100011) loads that word into rt.
- R6: BEQ (000100) and BNE (000101) compare rs with rt by subtraction. When taken, the next PC is PC+4 plus the sign-extended immediate shifted left by 2, backward targets included. Otherwise, and for every other non-jump instruction, the next PC is PC+4.
- R7: J (000010) sets the PC to {upper 4 bits of PC+4, target[25:0], 2'b00}.
- R8: JR (opcode 000000, funct 001000) loads the PC with the whole 32-bit value of rs.
- R9: An opcode outside the set above, or an unlisted funct, writes no register and no memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_we | input | 1 | Instruction memory write strobe |
| imem_addr | input | AW | Instruction word index to write |
| imem_data | input | 32 | Instruction word to write |
| pc_o | output | 32 | Current program counter |
| wb_en | output | 1 | A register is written at the coming edge |
| wb_reg | output | 5 | Register number being written |
| wb_data | output | 32 | Value being written to the register |
| mem_we | output | 1 | The data memory is written at the coming edge |
| mem_addr | output | 32 | Byte address of the load or store |
| mem_wdata | output | 32 | Store data |

## Verification
Control flow is the hardest part to expose. A jump through a register needs a full 32-bit address, which the program first assembles with an upper-immediate load followed by an OR-immediate. Branches must be shown both taken and not taken with equal and unequal operands. The stimulus therefore places filler instructions after every taken branch and jump, so that any wrong next PC appears either as a PC mismatch or as an unexpected write. The program ends in a backward branch to itself, which checks a negative displacement and holds the core steady for a reset applied mid-run.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int          AW       = 8,
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          imem_we,
  input  logic [AW-1:0] imem_addr,
  input  logic [31:0]   imem_data,
  output logic [31:0]   pc_o,
  output logic          wb_en,
  output logic [4:0]    wb_reg,
  output logic [31:0]   wb_data,
  output logic          mem_we,
  output logic [31:0]   mem_addr,
  output logic [31:0]   mem_wdata
);
  localparam int DEPTH = 1 << AW;

  localparam logic [5:0] OP_RR = 6'b000000, OP_J    = 6'b000010, OP_BEQ = 6'b000100,
                         OP_BNE = 6'b000101, OP_ADDI = 6'b001000, OP_ORI = 6'b001101,
                         OP_LUI = 6'b001111, OP_LW   = 6'b100011, OP_SW  = 6'b101011;
  localparam logic [5:0] FN_SLL = 6'b000000, FN_SRL = 6'b000010, FN_SRA = 6'b000011,
                         FN_JR  = 6'b001000, FN_ADD = 6'b100000, FN_SUB = 6'b100010,
                         FN_AND = 6'b100100, FN_OR  = 6'b100101, FN_XOR = 6'b100110,
                         FN_NOR = 6'b100111, FN_SLT = 6'b101010;

  logic [31:0] pc;
  logic [31:0] imem [DEPTH];
  logic [31:0] dmem [DEPTH];
  logic [31:0] rf   [32];

  wire [31:0] instr  = imem[pc[AW+1:2]];
  wire [5:0]  opcode = instr[31:26];
  wire [4:0]  rs     = instr[25:21];
  wire [4:0]  rt     = instr[20:16];
  wire [4:0]  rd     = instr[15:11];
  wire [4:0]  shamt  = instr[10:6];
  wire [5:0]  funct  = instr[5:0];
  wire [15:0] imm    = instr[15:0];

  wire [31:0] rs_v  = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] rt_v  = (rt == 5'd0) ? 32'd0 : rf[rt];
  wire [31:0] imm_s = {{16{imm[15]}}, imm};
  wire [31:0] imm_z = {16'h0, imm};
  wire [31:0] diff  = rs_v - rt_v;
  wire        zero  = (diff == 32'd0);
  wire [31:0] addr  = rs_v + imm_s;

  wire [31:0] pc_plus4  = pc + 32'd4;
  wire [31:0] br_target = pc_plus4 + {imm_s[29:0], 2'b00};
  wire [31:0] j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};

  logic        reg_we, st, ld, take_br, take_j, take_jr;
  logic [4:0]  dst;
  logic [31:0] result;

  always_comb begin
    reg_we = 1'b0; st = 1'b0; ld = 1'b0;
    take_br = 1'b0; take_j = 1'b0; take_jr = 1'b0;
    dst = rt; result = 32'd0;
    case (opcode)
      OP_RR: begin
        dst = rd;
        reg_we = 1'b1;
        case (funct)
          FN_ADD: result = rs_v + rt_v;
          FN_SUB: result = diff;
          FN_AND: result = rs_v & rt_v;
          FN_OR:  result = rs_v | rt_v;
          FN_XOR: result = rs_v ^ rt_v;
          FN_NOR: result = ~(rs_v | rt_v);
          FN_SLT: result = {31'd0, $signed(rs_v) < $signed(rt_v)};
          FN_SLL: result = rt_v << shamt;
          FN_SRL: result = rt_v >> shamt;
          FN_SRA: result = $unsigned($signed(rt_v) >>> shamt);
          FN_JR:  begin reg_we = 1'b0; take_jr = 1'b1; end
          default: reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin reg_we = 1'b1; result = rs_v + imm_s; end
      OP_ORI:  begin reg_we = 1'b1; result = rs_v | imm_z; end
      OP_LUI:  begin reg_we = 1'b1; result = {imm, 16'h0}; end
      OP_LW:   begin reg_we = 1'b1; ld = 1'b1; end
      OP_SW:   st = 1'b1;
      OP_BEQ:  take_br = zero;
      OP_BNE:  take_br = ~zero;
      OP_J:    take_j = 1'b1;
      default: ;
    endcase
  end

  wire [31:0] next_pc = take_jr ? rs_v :
                        take_j  ? j_target :
                        take_br ? br_target : pc_plus4;

  assign pc_o      = pc;
  assign wb_en     = rst_n & reg_we & (dst != 5'd0);
  assign wb_reg    = dst;
  assign wb_data   = ld ? dmem[addr[AW+1:2]] : result;
  assign mem_we    = rst_n & st;
  assign mem_addr  = addr;
  assign mem_wdata = rt_v;

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= RESET_PC;
    else        pc <= next_pc;
  end

  always_ff @(posedge clk) begin
    if (wb_en) rf[dst] <= wb_data;
  end

  always_ff @(posedge clk) begin
    if (mem_we) dmem[addr[AW+1:2]] <= rt_v;
  end

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_addr] <= imem_data;
  end
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        wb_en,
  input logic [4:0]  wb_reg,
  input logic        mem_we
);
  wire [5:0] op   = instr[31:26];
  wire       is_j  = (op == 6'b000010);
  wire       is_jr = (op == 6'b000000) && (instr[5:0] == 6'b001000);
  wire       is_br = (op == 6'b000100) || (op == 6'b000101);
  wire       known = (op == 6'b000000) || is_j || is_br || (op == 6'b001000) ||
                     (op == 6'b001101) || (op == 6'b001111) || (op == 6'b100011) ||
                     (op == 6'b101011);

  // R1
  reset_pc_chk: assert property (@(posedge clk) !rst_n |=> pc == RESET_PC);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!wb_en && !mem_we));

  // R4
  no_r0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_reg != 5'd0);

  // R5
  one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_en && mem_we));

  // R6
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_j && !is_jr && !is_br) |=> pc == $past(pc) + 32'd4);

  // R7
  jump_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_j |=> pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00});

  // R9
  unknown_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> (!wb_en && !mem_we));
endmodule

bind sc_core sc_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .instr(instr),
  .wb_en(wb_en), .wb_reg(wb_reg), .mem_we(mem_we)
);

// File: tb/sc_core_tb.sv
module sc_core_tb;
  localparam int AW = 8;
  localparam logic [31:0] RST_PC = 32'h0040_0000;
  localparam int NPROG = 42;
  localparam int NSTEP = 31;

  // kind: 0 = no write, 1 = register write, 2 = memory write
  localparam logic [5:0] EXP_IDX [NSTEP] = '{
    6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7, 6'd8, 6'd9, 6'd10,
    6'd11, 6'd12, 6'd13, 6'd14, 6'd15, 6'd16, 6'd17, 6'd18, 6'd19, 6'd20,
    6'd23, 6'd24, 6'd26, 6'd27, 6'd30, 6'd31, 6'd32, 6'd40, 6'd41, 6'd41};
  localparam logic [1:0] EXP_KIND [NSTEP] = '{
    2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1,
    2'd1, 2'd1, 2'd1, 2'd0, 2'd2, 2'd2, 2'd1, 2'd1, 2'd1, 2'd0,
    2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0, 2'd0, 2'd0};
  localparam logic [31:0] EXP_A [NSTEP] = '{
    32'd1, 32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd6, 32'd7, 32'd8, 32'd9, 32'd10,
    32'd11, 32'd12, 32'd13, 32'd0, 32'd8, 32'd12, 32'd14, 32'd15, 32'd16, 32'd0,
    32'd0, 32'd0, 32'd0, 32'd0, 32'd18, 32'd18, 32'd0, 32'd0, 32'd0, 32'd0};
  localparam logic [31:0] EXP_D [NSTEP] = '{
    32'h1234_0000, 32'h1234_5678, 32'hFFFF_FFFC, 32'h1234_5674, 32'hEDCB_A984,
    32'h1234_5678, 32'hFFFF_FFFC, 32'hEDCB_A984, 32'hEDCB_A987, 32'h0000_0001,
    32'h0000_8000, 32'h2345_6780, 32'hFFFF_FFFE, 32'h0000_000F, 32'h0,
    32'h1234_5678, 32'h0, 32'h1234_5678, 32'h0000_0010, 32'h1234_5678, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0040_0000, 32'h0040_00A0, 32'h0, 32'h0, 32'h0, 32'h0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          imem_we = 1'b0;
  logic [AW-1:0] imem_addr = '0;
  logic [31:0]   imem_data = '0;
  logic [31:0]   pc_o, wb_data, mem_addr, mem_wdata;
  logic          wb_en, mem_we;
  logic [4:0]    wb_reg;
  logic [31:0]   prog [NPROG];
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sc_core #(.AW(AW), .RESET_PC(RST_PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_addr(imem_addr),
    .imem_data(imem_data), .pc_o(pc_o), .wb_en(wb_en), .wb_reg(wb_reg),
    .wb_data(wb_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                        logic [4:0] sh, logic [5:0] fn);
    return {6'b000000, rs, rt, rd, sh, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                        logic [15:0] im);
    return {op, rs, rt, im};
  endfunction

  function automatic string tag(int idx);
    if (idx < 0) return "R1";
    if (idx <= 2 || idx == 10 || idx == 30 || idx == 31) return "R3";
    if (idx <= 13) return "R2";
    if (idx == 14 || idx == 16) return "R4";
    if (idx <= 19) return "R5";
    if (idx == 27) return "R7";
    if (idx == 32) return "R8";
    if (idx == 40) return "R9";
    return "R6";
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_step(int s);
    string t;
    t = tag(int'(EXP_IDX[s]));
    chk((s == 0) ? "R1" : tag(int'(EXP_IDX[s-1])), "pc", pc_o,
        RST_PC + {24'd0, EXP_IDX[s], 2'b00});
    case (EXP_KIND[s])
      2'd1: begin
        chk(t, "wb_en", {31'd0, wb_en}, 32'd1);
        chk(t, "wb_reg", {27'd0, wb_reg}, EXP_A[s]);
        chk(t, "wb_data", wb_data, EXP_D[s]);
        chk(t, "mem_we", {31'd0, mem_we}, 32'd0);
      end
      2'd2: begin
        chk(t, "mem_we", {31'd0, mem_we}, 32'd1);
        chk(t, "mem_addr", mem_addr, EXP_A[s]);
        chk(t, "mem_wdata", mem_wdata, EXP_D[s]);
        chk(t, "wb_en", {31'd0, wb_en}, 32'd0);
      end
      default: begin
        chk(t, "wb_en", {31'd0, wb_en}, 32'd0);
        chk(t, "mem_we", {31'd0, mem_we}, 32'd0);
      end
    endcase
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NPROG; i++) prog[i] = enc_i(6'h08, 5'd0, 5'd17, 16'd9);
    prog[0]  = enc_i(6'h0F, 5'd0, 5'd1, 16'h1234);
    prog[1]  = enc_i(6'h0D, 5'd1, 5'd1, 16'h5678);
    prog[2]  = enc_i(6'h08, 5'd0, 5'd2, 16'hFFFC);
    prog[3]  = enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h20);
    prog[4]  = enc_r(5'd2, 5'd1, 5'd4, 5'd0, 6'h22);
    prog[5]  = enc_r(5'd1, 5'd2, 5'd5, 5'd0, 6'h24);
    prog[6]  = enc_r(5'd1, 5'd2, 5'd6, 5'd0, 6'h25);
    prog[7]  = enc_r(5'd1, 5'd2, 5'd7, 5'd0, 6'h26);
    prog[8]  = enc_r(5'd1, 5'd0, 5'd8, 5'd0, 6'h27);
    prog[9]  = enc_r(5'd2, 5'd1, 5'd9, 5'd0, 6'h2A);
    prog[10] = enc_i(6'h0D, 5'd0, 5'd10, 16'h8000);
    prog[11] = enc_r(5'd0, 5'd1, 5'd11, 5'd4, 6'h00);
    prog[12] = enc_r(5'd0, 5'd2, 5'd12, 5'd1, 6'h03);
    prog[13] = enc_r(5'd0, 5'd2, 5'd13, 5'd28, 6'h02);
    prog[14] = enc_i(6'h08, 5'd0, 5'd0, 16'd5);
    prog[15] = enc_i(6'h2B, 5'd0, 5'd1, 16'd8);
    prog[16] = enc_i(6'h2B, 5'd0, 5'd0, 16'd12);
    prog[17] = enc_i(6'h23, 5'd0, 5'd14, 16'd8);
    prog[18] = enc_i(6'h08, 5'd0, 5'd15, 16'd16);
    prog[19] = enc_i(6'h23, 5'd15, 5'd16, 16'hFFF8);
    prog[20] = enc_i(6'h04, 5'd1, 5'd14, 16'd2);
    prog[23] = enc_i(6'h05, 5'd1, 5'd14, 16'd5);
    prog[24] = enc_i(6'h05, 5'd1, 5'd2, 16'd1);
    prog[26] = enc_i(6'h04, 5'd1, 5'd2, 16'd5);
    prog[27] = {6'h02, 26'h010_001E};
    prog[30] = enc_i(6'h0F, 5'd0, 5'd18, 16'h0040);
    prog[31] = enc_i(6'h0D, 5'd18, 5'd18, 16'h00A0);
    prog[32] = enc_r(5'd18, 5'd0, 5'd0, 5'd0, 6'h08);
    prog[40] = 32'hFFFF_FFFF;
    prog[41] = enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF);

    for (int i = 0; i < NPROG; i++) begin
      @(negedge clk);
      imem_we = 1'b1; imem_addr = AW'(i); imem_data = prog[i];
    end
    @(negedge clk);
    imem_we = 1'b0;
    #1;
    // R1: held in reset
    chk("R1", "reset pc", pc_o, RST_PC);
    chk("R1", "reset wb_en", {31'd0, wb_en}, 32'd0);
    chk("R1", "reset mem_we", {31'd0, mem_we}, 32'd0);

    @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int s = 0; s < NSTEP; s++) begin
      check_step(s);
      @(negedge clk);
      #1;
    end

    // R1: reset applied mid-run
    rst_n = 1'b0;
    #1;
    chk("R1", "mid reset wb_en", {31'd0, wb_en}, 32'd0);
    chk("R1", "mid reset mem_we", {31'd0, mem_we}, 32'd0);
    @(negedge clk);
    #1;
    chk("R1", "mid reset pc", pc_o, RST_PC);
    rst_n = 1'b1;
    #1;
    check_step(0);
    @(negedge clk);
    #1;
    check_step(1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule